// File: doc/BRIEF.md
# Tracklet Segment Router

This block steers a stream of tracklets to per-segment output lanes. Each incoming tracklet carries an opaque payload and one precomputed projected coordinate for each of two target layers. For every layer the coordinate range covers three sectors of twelve segments each, which gives 36 equal-width bins. The tracklet is copied into the lane of the bin that holds its projection. Neighbouring bins overlap by a margin of one tenth of a bin width, so a projection that falls near a bin edge is written to both adjacent lanes in the same transfer.

The two layers give 72 lanes. Each lane has a small FIFO and its own valid/ready output stream. The input accepts a tracklet only when every lane that tracklet targets has space. Nothing is written until that holds, so a tracklet is never partly delivered. A projection beyond the three-sector range is discarded for its layer, and each such discard increments a drop counter.

Top module: `seg_router`

## Requirements
- R1: With default parameters (bin width 112, margin 11, 12-bit coordinates), a projection at coordinate p in [0, 4031] falls in bin s = floor(p/112) with offset p - 112*s. When the offset is in [11, 100], the payload goes only to lane layer*36 + s, where layer 0 uses coordinate bits [11:0] and layer 1 uses bits [23:12].
- R2: An offset below 11 with s > 0 also writes lane layer*36 + s - 1 in the same transfer. An offset of exactly 11 does not.
- R3: An offset of 101 or more with s < 35 also writes lane layer*36 + s + 1 in the same transfer.
- R4: There is no wrap at the ends of the range. Coordinates 0..10 reach only bin 0, and coordinates 4021..4031 reach only bin 35.
- R5: The two layers are routed independently in the same transfer, so one tracklet can write up to four lanes.
- R6: A coordinate of 4032 or more writes no lane for that layer. On acceptance the drop counter rises by the number of layers discarded (0, 1 or 2). The counter is 0 after reset.
- R7: in_ready_o is low while any lane targeted by the presented tracklet holds 4 entries. In that case no lane is written and the drop counter does not change. A full lane that the tracklet does not target does not block it.
- R8: A lane's out_valid_o rises on the clock edge after an accepting edge, and the lane delivers its payloads in arrival order.
- R9: After reset all out_valid_o bits are low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Tracklet present |
| in_ready_o | output | 1 | All targeted lanes have space |
| in_data_i | input | DATA_W (30) | Tracklet payload |
| in_pos_i | input | NUM_LAYERS*COORD_W (24) | Projected coordinate per layer, layer 0 in the low bits |
| out_valid_o | output | NLANES (72) | Per-lane data available, lane = layer*36 + bin |
| out_ready_i | input | NLANES (72) | Per-lane consumer ready |
| out_data_o | output | NLANES*DATA_W (2160) | Per-lane head payload, lane k in bits [k*30 +: 30] |
| drop_cnt_o | output | DROP_W (16) | Count of discarded out-of-range projections |

## Verification
Overlap duplication and backpressure can act in the same cycle. A boundary tracklet targets two lanes, and if one of them is full the whole tracklet must stall, with no copy reaching the free neighbour. The bench first fills one lane to its depth. It then presents a tracklet whose overlap pair includes that full lane, and whose other layer is out of range. While the tracklet is held, the bench checks that in_ready_o stays low, that the free neighbour lane stays empty, and that the drop counter does not move.

// File: rtl/seg_router_pkg.sv
package seg_router_pkg;
  localparam int SECTORS_DEF      = 3;
  localparam int SEGS_PER_SEC_DEF = 12;
  localparam int LAYERS_DEF       = 2;
  localparam int COORD_W_DEF      = 12;
  localparam int BIN_W_DEF        = 112;
  localparam int DATA_W_DEF       = 30;
  localparam int FIFO_DEPTH_DEF   = 4;
  localparam int DROP_W_DEF       = 16;

  function automatic int lane_of(input int layer, input int seg, input int nseg);
    return layer * nseg + seg;
  endfunction
endpackage

// File: rtl/seg_locator.sv
module seg_locator #(
  parameter int COORD_W = 12,
  parameter int NSEG    = 36,
  parameter int BIN_W   = 112
) (
  input  logic [COORD_W-1:0] pos_i,
  output logic [NSEG-1:0]    hit_o,
  output logic               drop_o
);
  localparam int MARGIN = BIN_W / 10;
  localparam int SPAN   = NSEG * BIN_W;
  localparam logic [COORD_W:0] SPAN_V = (COORD_W+1)'(SPAN);

  logic [COORD_W:0] pos_x;
  assign pos_x  = {1'b0, pos_i};
  assign drop_o = (pos_x >= SPAN_V);

  // One window comparison per bin, widened by the margin on both sides
  for (genvar s = 0; s < NSEG; s++) begin : g_bin
    localparam int LO = (s == 0) ? 0 : s * BIN_W - MARGIN;
    localparam int HI = (s == NSEG-1) ? SPAN - 1 : (s + 1) * BIN_W + MARGIN - 1;
    localparam logic [COORD_W:0] LO_V = (COORD_W+1)'(LO);
    localparam logic [COORD_W:0] HI_V = (COORD_W+1)'(HI);
    assign hit_o[s] = (pos_x >= LO_V) && (pos_x <= HI_V);
  end

  always_comb begin
    assert_two_targets_max_R2: assert ($countones(hit_o) <= 2);
    if (drop_o) begin
      assert_drop_no_target_R6: assert (hit_o == '0);
    end
  end
endmodule

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int DATA_W = 30,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              full_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_V  = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              pop;

  assign full_o  = (count == DEPTH_V);
  assign valid_o = (count != '0);
  assign pop     = valid_o && ready_i;
  assign data_o  = mem[rd_ptr];

  // Storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST_V) ? '0 : wr_ptr + 1'b1;
      if (pop)    rd_ptr <= (rd_ptr == LAST_V) ? '0 : rd_ptr + 1'b1;
      case ({push_i, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    !(push_i && full_o));
  assert_push_visible_R8: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop) |=> valid_o);
endmodule

// File: rtl/seg_router.sv
module seg_router
  import seg_router_pkg::*;
#(
  parameter int SECTORS      = SECTORS_DEF,
  parameter int SEGS_PER_SEC = SEGS_PER_SEC_DEF,
  parameter int NUM_LAYERS   = LAYERS_DEF,
  parameter int COORD_W      = COORD_W_DEF,
  parameter int BIN_W        = BIN_W_DEF,
  parameter int DATA_W       = DATA_W_DEF,
  parameter int FIFO_DEPTH   = FIFO_DEPTH_DEF,
  parameter int DROP_W       = DROP_W_DEF,
  localparam int NSEG        = SECTORS * SEGS_PER_SEC,
  localparam int NLANES      = NSEG * NUM_LAYERS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [DATA_W-1:0]             in_data_i,
  input  logic [NUM_LAYERS*COORD_W-1:0] in_pos_i,
  output logic [NLANES-1:0]             out_valid_o,
  input  logic [NLANES-1:0]             out_ready_i,
  output logic [NLANES*DATA_W-1:0]      out_data_o,
  output logic [DROP_W-1:0]             drop_cnt_o
);
  logic [NLANES-1:0]     target;
  logic [NLANES-1:0]     lane_full;
  logic [NUM_LAYERS-1:0] layer_drop;
  logic                  accept;
  logic [DROP_W-1:0]     drop_add;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    seg_locator #(.COORD_W(COORD_W), .NSEG(NSEG), .BIN_W(BIN_W)) loc_i (
      .pos_i  (in_pos_i[l*COORD_W +: COORD_W]),
      .hit_o  (target[lane_of(l, 0, NSEG) +: NSEG]),
      .drop_o (layer_drop[l])
    );
  end

  assign in_ready_o = ~|(target & lane_full);
  assign accept     = in_valid_i && in_ready_o;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    lane_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk     (clk),
      .rst     (rst),
      .push_i  (accept && target[k]),
      .data_i  (in_data_i),
      .full_o  (lane_full[k]),
      .valid_o (out_valid_o[k]),
      .ready_i (out_ready_i[k]),
      .data_o  (out_data_o[k*DATA_W +: DATA_W])
    );
  end

  always_comb drop_add = DROP_W'($countones(layer_drop));

  always_ff @(posedge clk) begin
    if (rst)         drop_cnt_o <= '0;
    else if (accept) drop_cnt_o <= drop_cnt_o + drop_add;
  end

  assert_stall_holds_count_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !in_ready_o) |=> $stable(drop_cnt_o));
  assert_drop_counted_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && |layer_drop) |=> (drop_cnt_o != $past(drop_cnt_o)));
endmodule

// File: tb/seg_router_tb_top.sv
module seg_router_tb_top;
  localparam int DW = 30;
  localparam int NL = 72;
  localparam int NS = 36;
  localparam int NV = 8;

  // p0, p1, layer0 bins (a,b), layer1 bins (a,b); -1 = none
  localparam int VEC [NV][6] = '{
    '{  50, 1000,  0, -1,  8,  9},
    '{   5,  227,  0, -1,  2,  1},
    '{4031, 4032, 35, -1, -1, -1},
    '{4095, 4095, -1, -1, -1, -1},
    '{2000, 1344, 17, -1, 12, 11},
    '{1343, 2687, 11, 12, 23, 24},
    '{ 122,  123,  1,  0,  1, -1},
    '{ 100,  101,  0, -1,  0,  1}
  };
  localparam string VREQ [NV] = '{"R1 R3", "R4 R2", "R4 R6", "R6", "R1 R2", "R3 R5",
                                  "R2", "R3"};

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid_i;
  logic              in_ready_o;
  logic [DW-1:0]     in_data_i;
  logic [23:0]       in_pos_i;
  logic [NL-1:0]     out_valid_o;
  logic [NL-1:0]     out_ready_i;
  logic [NL*DW-1:0]  out_data_o;
  logic [15:0]       drop_cnt_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_router dut_i (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .in_pos_i(in_pos_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_data_o(out_data_o), .drop_cnt_o(drop_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_data(input int k);
    return out_data_o[k*DW +: DW];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int exp_drop;
    logic [NL-1:0] m;
    rst = 1'b1; in_valid_i = 1'b0; in_data_i = '0; in_pos_i = '0; out_ready_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(out_valid_o == '0, "R9 out_valid after reset", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R9 in_ready after reset", in_ready_o, 1);
    chk(drop_cnt_o == '0, "R6 drop count after reset", drop_cnt_o, 0);

    exp_drop = 0;
    for (int v = 0; v < NV; v++) begin
      m = '0;
      for (int l = 0; l < 2; l++) begin
        if (VEC[v][2+2*l] < 0) exp_drop++;
        for (int j = 0; j < 2; j++)
          if (VEC[v][2+2*l+j] >= 0) m[l*NS + VEC[v][2+2*l+j]] = 1'b1;
      end
      in_valid_i = 1'b1;
      in_pos_i   = {12'(VEC[v][1]), 12'(VEC[v][0])};
      in_data_i  = DW'(32'h100 + v);
      @(negedge clk);
      in_valid_i = 1'b0;
      chk(out_valid_o == m, {"lane set ", VREQ[v]}, out_valid_o, m);
      for (int k = 0; k < NL; k++)
        if (m[k]) chk(lane_data(k) == DW'(32'h100 + v), {"lane payload ", VREQ[v]},
                      lane_data(k), 32'h100 + v);
      chk(drop_cnt_o == 16'(exp_drop), "R6 drop count", drop_cnt_o, exp_drop);
      out_ready_i = '1;
      @(negedge clk);
      out_ready_i = '0;
      chk(out_valid_o == '0, "R8 lanes drained", out_valid_o, 0);
    end

    // R7/R8: fill lane 0 and lane 62 (layer1 bin 26) to depth 4
    for (int i = 0; i < 4; i++) begin
      in_valid_i = 1'b1; in_pos_i = {12'd3000, 12'd50}; in_data_i = DW'(32'h200 + i);
      @(negedge clk);
    end
    chk(in_ready_o == 1'b0, "R7 ready low with targeted lane full", in_ready_o, 0);
    in_pos_i = {12'd3000, 12'd500};
    #1;
    chk(in_ready_o == 1'b0, "R7 one full target blocks", in_ready_o, 0);
    // Overlap pair 63/62 with 62 full; layer 0 out of range
    in_pos_i = {12'd3026, 12'd4095}; in_data_i = DW'(32'h3AA);
    #1;
    chk(in_ready_o == 1'b0, "R7 R2 overlap stall", in_ready_o, 0);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid_o[63] == 1'b0, "R7 no partial copy", out_valid_o[63], 0);
    chk(drop_cnt_o == 16'(exp_drop), "R7 drop count held while stalled", drop_cnt_o,
        exp_drop);
    // Untargeted full lanes do not block
    in_pos_i = {12'd1000, 12'd500}; in_data_i = DW'(32'h3BB);
    #1;
    chk(in_ready_o == 1'b1, "R7 untargeted full lane ignored", in_ready_o, 1);
    @(negedge clk);
    in_valid_i = 1'b0;
    chk(out_valid_o[4] && out_valid_o[44] && out_valid_o[45], "R5 accepted beside full lanes",
        {out_valid_o[45], out_valid_o[44], out_valid_o[4]}, 3'b111);
    // R8 order on lane 0
    out_ready_i[0] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(out_valid_o[0] && lane_data(0) == DW'(32'h200 + i), "R8 lane order",
          lane_data(0), 32'h200 + i);
      @(negedge clk);
    end
    chk(out_valid_o[0] == 1'b0, "R8 lane 0 empty after four pops", out_valid_o[0], 0);
    out_ready_i = '1;
    repeat (5) @(negedge clk);
    chk(out_valid_o == '0, "R8 all lanes drained", out_valid_o, 0);
    finish_run();
  end
endmodule